// File: doc/BRIEF.md
# Byte-Bus Serial Port with Receive Queue

This block is a small asynchronous serial port for 8N1 frames (eight data bits sent least significant bit first, no parity, one stop bit). Software drives it through a byte-wide register bus. Eight 8-bit registers sit on word-aligned byte offsets. Accesses whose two low address bits are not zero are ignored, and such reads return zero.

The transmit side has one holding slot that feeds a shift register. The receive side oversamples the line at four ticks per bit and places good characters into a four-entry queue. A 16-bit divisor sets the tick rate, so one bit lasts 4*(divisor+1) clock cycles. One status register holds three kinds of bit: the two interrupt enables, which software writes; two sticky error flags, which software can only clear; and the queue and holding flags, which are read-only. A single interrupt output serves both directions.

Top module: `uart8_ctrl`

## Requirements
- R1: After reset, both enables and both error flags are 0 and the receive queue is empty. The transmit slot reads empty, so the status register reads 0xA0. The serial output is high and the interrupt output is low.
- R2: The four identity bytes read back as constants: offset 0 returns DEV_ID[7:0], offset 4 returns DEV_ID[15:8], offset 8 returns DEV_ID[23:16] and offset 12 returns DEV_ID[31:24].
- R3: The divisor is {high byte at offset 28, low byte at offset 24}, and both bytes read back as written. Each serial bit lasts exactly 4*(divisor+1) clock cycles, and the serial output changes only on a tick.
- R4: A transmitted frame is one low start bit, then eight data bits least significant bit first, then one high stop bit. The line idles high.
- R5: A write to DATA (offset 16) is taken only while status bit 7 (transmit-empty) is 1. That bit clears on the write and sets again once the byte has moved into the shifter. A write made while the bit is 0 is dropped.
- R6: Each received good frame enters the queue. A read of DATA returns and removes the oldest entry. Status bit 5 means the queue is empty, bit 4 means exactly one free place remains (three entries held), and bit 3 means the queue is full (four entries held).
- R7: A character that completes while the queue holds four entries is dropped, and status bit 1 (overrun) is set. The four stored characters are unchanged.
- R8: A frame whose stop-bit sample is low sets status bit 0 (frame error) and is not queued. Both error flags stay set until software clears them.
- R9: A low pulse on the serial input that has ended by the middle of the start bit is ignored, and the receiver still takes the next real frame.
- R10: A write to STATUS (offset 20) loads bit 2 (receive enable) and bit 6 (transmit enable). Writing 0 to bit 0 or bit 1 clears that error flag, while writing 1 leaves it as it is. The write never changes bits 3, 4, 5 or 7.
- R11: The interrupt output is high when the receive enable is set and the queue is not empty or an error flag is set. It is also high when the transmit enable and transmit-empty are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| ser_rx_i | input | 1 | Serial input (asynchronous) |
| ser_tx_o | output | 1 | Serial output |
| irq_o | output | 1 | Shared interrupt |

## Verification
The assertions assume that each bus access is a single-cycle strobe, held stable around the clock edge. They also assume that the divisor does not change while a frame is on the line. The stimulus loads the divisor once, before any frame is sent. After that it drives the serial input only with whole bit periods of 4*(divisor+1) cycles, or with one deliberately short low pulse. Every bus access is issued at the falling clock edge and released at the next falling edge.

// File: rtl/uart8_pkg.sv
package uart8_pkg;
  localparam int ST_FERR  = 0;
  localparam int ST_OERR  = 1;
  localparam int ST_RXIE  = 2;
  localparam int ST_FULL  = 3;
  localparam int ST_ONE   = 4;
  localparam int ST_EMPTY = 5;
  localparam int ST_TXIE  = 6;
  localparam int ST_TXE   = 7;

  typedef enum logic [2:0] {
    REG_ID0, REG_ID1, REG_ID2, REG_ID3, REG_DATA, REG_STAT, REG_DIVL, REG_DIVH
  } reg_sel_e;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // True once the tick counter has reached the divisor.
  function automatic logic tick_due(input logic [15:0] cnt, input logic [15:0] div);
    return cnt >= div;
  endfunction
endpackage

// File: rtl/uart8_tick.sv
module uart8_tick
  import uart8_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = tick_due(16'(cnt_q), 16'(div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart8_rx.sv
module uart8_rx
  import uart8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  output logic       push_o,
  output logic       ferr_o,
  output logic [7:0] data_o
);
  logic [1:0] sync_q;
  logic       last_q;
  rx_state_e  st_q;
  logic [1:0] ph_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q;
  logic       line, mid;

  assign line   = sync_q[1];
  assign mid    = tick_i && (ph_q == 2'd1);
  assign push_o = mid && (st_q == RX_STOP) && line;
  assign ferr_o = mid && (st_q == RX_STOP) && !line;
  assign data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      last_q <= 1'b1;
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (tick_i) begin
        last_q <= line;
        ph_q   <= ph_q + 2'd1;
        case (st_q)
          RX_IDLE: if (last_q && !line) begin
            st_q <= RX_START;
            ph_q <= '0;
          end
          RX_START: begin
            bit_q <= '0;
            if (ph_q == 2'd1) st_q <= line ? RX_IDLE : RX_DATA;
          end
          RX_DATA: if (ph_q == 2'd1) begin
            sh_q  <= {line, sh_q[7:1]};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) st_q <= RX_STOP;
          end
          default: if (ph_q == 2'd1) st_q <= RX_IDLE;
        endcase
      end
    end
  end

  AST_STOP_AFTER_EIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_STOP) |-> (bit_q == 3'd0)); // R6
endmodule

// File: rtl/uart8_rxfifo.sv
module uart8_rxfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             one_left_o,
  output logic             overrun_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign one_left_o = (cnt_q == CNT_W'(DEPTH - 1));
  assign do_pop     = pop_i && !empty_o;
  assign do_push    = push_i && (!full_o || do_pop);
  assign overrun_o  = push_i && !do_push;
  assign dout_o     = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wrap_inc(wr_q);
      if (do_pop)  rd_q <= wrap_inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  AST_POP_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o); // R6
  AST_FULL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(wr_q))); // R7
endmodule

// File: rtl/uart8_tx.sv
module uart8_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] din_i,
  output logic       empty_o,
  output logic       txd_o
);
  logic       hold_v_q, busy_q, txd_q;
  logic [7:0] hold_q;
  logic [8:0] sh_q;
  logic [1:0] ph_q;
  logic [3:0] cnt_q;
  logic       last_end, load;

  assign last_end = busy_q && tick_i && (ph_q == 2'd3) && (cnt_q == 4'd9);
  assign load     = tick_i && hold_v_q && (!busy_q || last_end);
  assign empty_o  = !hold_v_q;
  assign txd_o    = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= '0;
      busy_q   <= 1'b0;
      sh_q     <= '1;
      ph_q     <= '0;
      cnt_q    <= '0;
      txd_q    <= 1'b1;
    end else begin
      if (load) hold_v_q <= 1'b0;
      else if (wr_i && !hold_v_q) begin
        hold_v_q <= 1'b1;
        hold_q   <= din_i;
      end
      if (load) begin
        txd_q  <= 1'b0;
        sh_q   <= {1'b1, hold_q};
        busy_q <= 1'b1;
        ph_q   <= '0;
        cnt_q  <= '0;
      end else if (busy_q && tick_i) begin
        ph_q <= ph_q + 2'd1;
        if (ph_q == 2'd3) begin
          if (cnt_q == 4'd9) busy_q <= 1'b0;
          else begin
            txd_q <= sh_q[0];
            sh_q  <= {1'b1, sh_q[8:1]};
            cnt_q <= cnt_q + 4'd1;
          end
        end
      end
    end
  end

  AST_TX_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_q) |-> $past(tick_i)); // R3
  AST_HOLD_KEPT_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hold_v_q) |=> $stable(hold_q)); // R5
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !$past(busy_q)) |-> txd_q); // R4
endmodule

// File: rtl/uart8_ctrl.sv
module uart8_ctrl
  import uart8_pkg::*;
#(
  parameter logic [31:0] DEV_ID     = 32'h5AC3017E,
  parameter logic [15:0] DIV_RST    = 16'd26,
  parameter int          FIFO_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_req_i,
  input  logic       bus_we_i,
  input  logic [4:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       ser_rx_i,
  output logic       ser_tx_o,
  output logic       irq_o
);
  localparam int DIV_W = 16;

  reg_sel_e         sel;
  logic             aligned, wr, rd, wr_data, pop, st_wr;
  logic [DIV_W-1:0] div_q;
  logic             rxie_q, txie_q, ferr_q, oerr_q;
  logic             tick, rx_push, ferr_evt, ovr_evt;
  logic [7:0]       rx_byte, fifo_dout, status, rd_mux;
  logic             q_empty, q_full, q_one, tx_empty;

  assign sel     = reg_sel_e'(bus_addr_i[4:2]);
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign wr      = bus_req_i && aligned && bus_we_i;
  assign rd      = bus_req_i && aligned && !bus_we_i;
  assign wr_data = wr && (sel == REG_DATA);
  assign st_wr   = wr && (sel == REG_STAT);
  assign pop     = rd && (sel == REG_DATA);

  uart8_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .div_i(div_q), .tick_o(tick)
  );

  uart8_rx i_rx (
    .clk_i, .rst_ni, .tick_i(tick), .rxd_i(ser_rx_i),
    .push_o(rx_push), .ferr_o(ferr_evt), .data_o(rx_byte)
  );

  uart8_rxfifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_fifo (
    .clk_i, .rst_ni, .push_i(rx_push), .din_i(rx_byte), .pop_i(pop),
    .dout_o(fifo_dout), .empty_o(q_empty), .full_o(q_full),
    .one_left_o(q_one), .overrun_o(ovr_evt)
  );

  uart8_tx i_tx (
    .clk_i, .rst_ni, .tick_i(tick), .wr_i(wr_data), .din_i(bus_wdata_i),
    .empty_o(tx_empty), .txd_o(ser_tx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= DIV_RST;
      rxie_q <= 1'b0;
      txie_q <= 1'b0;
      ferr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      if (wr && sel == REG_DIVL) div_q[7:0]  <= bus_wdata_i;
      if (wr && sel == REG_DIVH) div_q[15:8] <= bus_wdata_i;
      if (st_wr) begin
        rxie_q <= bus_wdata_i[ST_RXIE];
        txie_q <= bus_wdata_i[ST_TXIE];
      end
      ferr_q <= ferr_evt || (ferr_q && !(st_wr && !bus_wdata_i[ST_FERR]));
      oerr_q <= ovr_evt  || (oerr_q && !(st_wr && !bus_wdata_i[ST_OERR]));
    end
  end

  always_comb begin
    status           = '0;
    status[ST_FERR]  = ferr_q;
    status[ST_OERR]  = oerr_q;
    status[ST_RXIE]  = rxie_q;
    status[ST_FULL]  = q_full;
    status[ST_ONE]   = q_one;
    status[ST_EMPTY] = q_empty;
    status[ST_TXIE]  = txie_q;
    status[ST_TXE]   = tx_empty;
  end

  always_comb begin
    case (sel)
      REG_ID0:  rd_mux = DEV_ID[7:0];
      REG_ID1:  rd_mux = DEV_ID[15:8];
      REG_ID2:  rd_mux = DEV_ID[23:16];
      REG_ID3:  rd_mux = DEV_ID[31:24];
      REG_DATA: rd_mux = fifo_dout;
      REG_STAT: rd_mux = status;
      REG_DIVL: rd_mux = div_q[7:0];
      default:  rd_mux = div_q[15:8];
    endcase
  end

  assign bus_rdata_o = aligned ? rd_mux : 8'h00;
  assign irq_o = (rxie_q && (!q_empty || ferr_q || oerr_q)) || (txie_q && tx_empty);

  AST_FERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ferr_q && !(st_wr && !bus_wdata_i[ST_FERR])) |=> ferr_q); // R8
  AST_FERR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ferr_evt |=> ferr_q); // R8
  AST_OVERRUN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_evt |=> oerr_q); // R7
  AST_IRQ_TX_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txie_q && tx_empty) |-> irq_o); // R11
  AST_STATUS_WR_KEEPS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && !tick) |=> $stable(tx_empty)); // R10
endmodule

// File: tb/test_uart8_ctrl.sv
`timescale 1ns/1ps
module test_uart8_ctrl;
  localparam int DIV = 1;
  localparam int BIT = 4 * (DIV + 1);
  localparam int NV  = 13;
  // {we, addr[4:0], wdata[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'd0,  8'h00, 8'h7E},  // R2
    {1'b0, 5'd4,  8'h00, 8'h01},  // R2
    {1'b0, 5'd8,  8'h00, 8'hC3},  // R2
    {1'b0, 5'd12, 8'h00, 8'h5A},  // R2
    {1'b0, 5'd20, 8'h00, 8'hA0},  // R1
    {1'b1, 5'd24, 8'h01, 8'h00},  // R3
    {1'b1, 5'd28, 8'h00, 8'h00},  // R3
    {1'b0, 5'd24, 8'h00, 8'h01},  // R3
    {1'b0, 5'd28, 8'h00, 8'h00},  // R3
    {1'b1, 5'd20, 8'hFF, 8'h00},  // R10
    {1'b0, 5'd20, 8'h00, 8'hE4},  // R10
    {1'b1, 5'd20, 8'h00, 8'h00},  // R10
    {1'b0, 5'd20, 8'h00, 8'hA0}   // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ser_rx = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ser_tx, irq;
  int checks = 0, fails = 0;
  logic [7:0] cap [8];
  int ncap = 0, stop_bad = 0;

  always #2.5 clk = ~clk;

  uart8_ctrl i_uart8_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ser_rx_i(ser_rx), .ser_tx_o(ser_tx), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop_lvl);
    ser_rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    ser_rx = stop_lvl;
    repeat (BIT) @(negedge clk);
    ser_rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // Serial output monitor: samples mid-bit after each falling start edge.
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && ser_tx == 1'b0) begin
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          b[i] = ser_tx;
        end
        repeat (BIT) @(negedge clk);
        if (ser_tx !== 1'b1) stop_bad++;
        if (ncap < 8) cap[ncap] = b;
        ncap++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ser_tx idle", {7'd0, ser_tx}, 8'h01);
    check("R1 irq low", {7'd0, irq}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][21]) bus_wr(VEC[v][20:16], VEC[v][15:8]);
      else begin
        bus_rd(VEC[v][20:16], d);
        check(VEC[v][20:16] < 5'd16 ? "R2 id" : (VEC[v][20:16] == 5'd20 ? "R10 status" : "R3 divisor"),
              d, VEC[v][7:0]);
      end
    end
    check("R11 irq off", {7'd0, irq}, 8'h00);
    bus_rd(5'd1, d);
    check("R2 misaligned", d, 8'h00);

    // Transmit: holding slot and frames
    bus_wr(5'd16, 8'h35);
    bus_rd(5'd20, d);
    check("R5 txe clears on write", d, 8'h20);
    repeat (4) @(negedge clk);
    bus_rd(5'd20, d);
    check("R5 txe sets after move", d, 8'hA0);
    bus_wr(5'd16, 8'hC8);
    bus_wr(5'd16, 8'h11);
    bus_rd(5'd20, d);
    check("R5 slot full", d, 8'h20);
    repeat (30 * BIT) @(negedge clk);
    check("R4 frame count", 8'(ncap), 8'd2);
    check("R4 first frame", cap[0], 8'h35);
    check("R5 second frame, third dropped", cap[1], 8'hC8);
    check("R4 stop bits", 8'(stop_bad), 8'd0);
    check("R3 line idle", {7'd0, ser_tx}, 8'h01);

    // Receive queue
    bus_wr(5'd20, 8'h04);
    send(8'h81, 1'b1);
    check("R11 rx irq", {7'd0, irq}, 8'h01);
    send(8'h42, 1'b1);
    bus_rd(5'd20, d);
    check("R6 two held", d, 8'h84);
    bus_rd(5'd16, d);
    check("R6 oldest first", d, 8'h81);
    bus_rd(5'd16, d);
    check("R6 second", d, 8'h42);
    bus_rd(5'd20, d);
    check("R6 empty again", d, 8'hA4);
    check("R11 irq clear", {7'd0, irq}, 8'h00);

    send(8'h10, 1'b1);
    send(8'h20, 1'b1);
    send(8'h30, 1'b1);
    bus_rd(5'd20, d);
    check("R6 one place left", d, 8'h94);
    send(8'h40, 1'b1);
    bus_rd(5'd20, d);
    check("R6 full", d, 8'h8C);
    send(8'h55, 1'b1);
    bus_rd(5'd20, d);
    check("R7 overrun flag", d, 8'h8E);
    bus_rd(5'd16, d); check("R7 kept 1", d, 8'h10);
    bus_rd(5'd16, d); check("R7 kept 2", d, 8'h20);
    bus_rd(5'd16, d); check("R7 kept 3", d, 8'h30);
    bus_rd(5'd16, d); check("R7 kept 4", d, 8'h40);
    bus_rd(5'd20, d);
    check("R7 sticky, new char dropped", d, 8'hA6);
    check("R11 irq on error", {7'd0, irq}, 8'h01);
    bus_wr(5'd20, 8'hBD);
    bus_rd(5'd20, d);
    check("R10 clear overrun only", d, 8'hA4);

    // Frame error
    send(8'h66, 1'b0);
    bus_rd(5'd20, d);
    check("R8 frame error, not queued", d, 8'hA5);
    repeat (3 * BIT) @(negedge clk);
    bus_rd(5'd20, d);
    check("R8 still sticky", d, 8'hA5);
    bus_wr(5'd20, 8'h06);
    bus_rd(5'd20, d);
    check("R10 clear frame error", d, 8'hA4);

    // False start
    ser_rx = 1'b0;
    repeat (2) @(negedge clk);
    ser_rx = 1'b1;
    repeat (4 * BIT) @(negedge clk);
    bus_rd(5'd20, d);
    check("R9 glitch ignored", d, 8'hA4);
    send(8'h3C, 1'b1);
    bus_rd(5'd16, d);
    check("R9 recovers", d, 8'h3C);

    bus_wr(5'd20, 8'h40);
    check("R11 tx irq", {7'd0, irq}, 8'h01);

    summary();
    $finish;
  end
endmodule